// File: doc/BRIEF.md
# PHY Management Bus Master

This block runs single register accesses on the two-wire PHY management bus: a management clock line and one bidirectional data line. A host raises `start` for one cycle with a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then clocks out a whole frame and pulses `done` once when the frame is over. On a read it also returns the 16 data bits from the PHY or raises an error.

The management clock comes from the system clock. Each high phase and each low phase lasts `half_period` system cycles, so the bus rate is set at run time. The data line is driven through an output value and an output enable, and the tri-state pad sits outside the block. Every frame opens with a 33-bit run of ones, whether or not the PHY needs it.

On a read the block checks the second turnaround bit, which the PHY must pull low. If the line is still high there, the block stops the transfer and gives 32 more management clocks with the line released. It then ends the access with the error flag set and the read data forced to all ones.

Top module: `mgmt_bus_master`

## Requirements
- R1: After reset and between frames, `mdc` is low, `mdio_oe` is low and `done` is low.
- R2: Frame bits are numbered from 0 in the order they are sent. Bits 0 to 32 are all driven as one.
- R3: Bits 33 and 34 are driven as 0 then 1. Bits 35 and 36 carry the opcode: 1 then 0 for a read (`rd_nwr`=1), and 0 then 1 for a write.
- R4: Bits 37 to 41 carry `phy_addr` and bits 42 to 46 carry `reg_addr`, each most significant bit first.
- R5: On a write, bits 47 and 48 are driven as 1 then 0, and bits 49 to 64 carry `wr_data` most significant bit first. All 65 bits are driven.
- R6: On a read, `mdio_oe` is low from bit 47 to the end of the access.
- R7: On a read, `mdio_i` is sampled on each rising edge of `mdc`. If bit 48 samples low, bits 49 to 64 are taken as the read data, most significant bit first. The data appears on `rd_data` with `err` low when `done` pulses.
- R8: If bit 48 of a read samples high, the block gives exactly 32 further `mdc` cycles with `mdio_oe` low. It then pulses `done` with `err` high and `rd_data` equal to 16'hFFFF.
- R9: Each `mdc` high phase and low phase lasts `half_period` system cycles, and a value of 0 is treated as 1. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R10: `done` is a single-cycle pulse that comes on the falling `mdc` edge after the last bit. In that same cycle `mdc` and `mdio_oe` are already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | DIV_W | System cycles in each management clock phase (0 acts as 1) |
| start | input | 1 | One-cycle request strobe, taken while idle |
| rd_nwr | input | 1 | 1 for a read, 0 for a write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Data to write |
| rd_data | output | 16 | Read result, all ones after a turnaround error |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Turnaround error of the last access, valid from `done` until the next start |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The phase-length and output-stability properties assume that `half_period` stays constant while an access is running. The stimulus changes it only while the block is idle and waits for `done` before it changes it again. The properties also assume that `start` arrives only while the block is idle. The bench raises it only after the previous `done`. The modelled PHY drives `mdio_i` only while `mdio_oe` is low, changes it on falling `mdc` edges, and otherwise leaves a pulled-up level of one on the line.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   // sequencer phases
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FRAME = 2'd1,
      SEQ_RECOV = 2'd2
   } seq_state_t;

   // fixed frame geometry shared by builder and sequencer
   localparam int unsigned PRE_BITS   = 33;
   localparam int unsigned RECOV_BITS = 32;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_period,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] last_cnt;

   // a zero setting behaves as one cycle per phase
   always_comb begin
      last_cnt = (half_period == '0) ? '0 : half_period - 1'b1;
      tick     = run && (cnt_q == last_cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mgmt_frame_build.sv
module mgmt_frame_build #(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned PRE_BITS = 33,
   localparam int unsigned TA0       = PRE_BITS + 4 + 2 * ADDR_W,
   localparam int unsigned FRAME_LEN = TA0 + 2 + DATA_W
) (
   input  logic                 rd,
   input  logic [ADDR_W-1:0]    phy,
   input  logic [ADDR_W-1:0]    regn,
   input  logic [DATA_W-1:0]    wdata,
   output logic [FRAME_LEN-1:0] bits,
   output logic [FRAME_LEN-1:0] drive
);
   localparam int unsigned ST0  = PRE_BITS;
   localparam int unsigned PHY0 = PRE_BITS + 4;
   localparam int unsigned REG0 = PHY0 + ADDR_W;
   localparam int unsigned DAT0 = TA0 + 2;

   // bit i of the vectors goes out i-th on the line
   for (genvar i = 0; i < PRE_BITS; i++) begin : g_pre
      assign bits[i] = 1'b1;
   end

   assign bits[ST0]     = 1'b0;
   assign bits[ST0 + 1] = 1'b1;
   assign bits[ST0 + 2] = rd;
   assign bits[ST0 + 3] = ~rd;

   for (genvar j = 0; j < ADDR_W; j++) begin : g_addr
      assign bits[PHY0 + j] = phy[ADDR_W-1-j];
      assign bits[REG0 + j] = regn[ADDR_W-1-j];
   end

   assign bits[TA0]     = 1'b1;
   assign bits[TA0 + 1] = 1'b0;

   for (genvar j = 0; j < DATA_W; j++) begin : g_data
      assign bits[DAT0 + j] = wdata[DATA_W-1-j];
   end

   // a read releases the line from the first turnaround bit on
   for (genvar i = 0; i < FRAME_LEN; i++) begin : g_drive
      if (i < TA0) begin : g_hdr
         assign drive[i] = 1'b1;
      end else begin : g_tail
         assign drive[i] = ~rd;
      end
   end
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
   import mgmt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned FRAME_LEN = 65,
   parameter int unsigned RECOV_LEN = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 rd,
   input  logic [FRAME_LEN-1:0] frame_in,
   input  logic [FRAME_LEN-1:0] drive_in,
   input  logic                 tick,
   input  logic                 mdio_i,
   output logic                 run,
   output logic                 mdc,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 done,
   output logic                 err
);
   localparam int unsigned IDX_W   = $clog2(FRAME_LEN + 1);
   localparam int unsigned RC_W    = $clog2(RECOV_LEN + 1);
   localparam int unsigned DAT0    = FRAME_LEN - DATA_W;
   localparam logic [IDX_W-1:0] TA_CHK   = IDX_W'(DAT0 - 1);
   localparam logic [IDX_W-1:0] DAT_FIRST = IDX_W'(DAT0);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
   localparam logic [RC_W-1:0]  RC_LAST  = RC_W'(RECOV_LEN - 1);

   seq_state_t           st_q;
   logic [FRAME_LEN-1:0] bits_q;
   logic [FRAME_LEN-1:0] drv_q;
   logic [IDX_W-1:0]     idx_q;
   logic [RC_W-1:0]      rc_q;
   logic [DATA_W-1:0]    shin_q;
   logic                 rd_q;
   logic                 ta_bad_q;

   assign run = (st_q != SEQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         bits_q   <= '0;
         drv_q    <= '0;
         idx_q    <= '0;
         rc_q     <= '0;
         shin_q   <= '0;
         rd_q     <= 1'b0;
         ta_bad_q <= 1'b0;
         mdc      <= 1'b0;
         mdio_o   <= 1'b0;
         mdio_oe  <= 1'b0;
         rd_data  <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: begin
               mdc <= 1'b0;
               if (start) begin
                  st_q     <= SEQ_FRAME;
                  bits_q   <= frame_in;
                  drv_q    <= drive_in;
                  mdio_o   <= frame_in[0];
                  mdio_oe  <= drive_in[0];
                  idx_q    <= '0;
                  rd_q     <= rd;
                  ta_bad_q <= 1'b0;
                  err      <= 1'b0;
               end
            end
            SEQ_FRAME: begin
               if (tick && !mdc) begin
                  // rising edge: sample the line
                  mdc <= 1'b1;
                  if (rd_q && idx_q == TA_CHK) begin
                     ta_bad_q <= mdio_i;
                  end
                  if (rd_q && idx_q >= DAT_FIRST) begin
                     shin_q <= {shin_q[DATA_W-2:0], mdio_i};
                  end
               end else if (tick) begin
                  // falling edge: move on to the next bit
                  mdc <= 1'b0;
                  if (rd_q && idx_q == TA_CHK && ta_bad_q) begin
                     st_q    <= SEQ_RECOV;
                     rc_q    <= '0;
                     mdio_oe <= 1'b0;
                  end else if (idx_q == LAST_IDX) begin
                     st_q    <= SEQ_IDLE;
                     mdio_oe <= 1'b0;
                     mdio_o  <= 1'b0;
                     done    <= 1'b1;
                     if (rd_q) begin
                        rd_data <= shin_q;
                     end
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     bits_q  <= bits_q >> 1;
                     drv_q   <= drv_q >> 1;
                     mdio_o  <= bits_q[1];
                     mdio_oe <= drv_q[1];
                  end
               end
            end
            SEQ_RECOV: begin
               if (tick && !mdc) begin
                  mdc <= 1'b1;
               end else if (tick) begin
                  mdc <= 1'b0;
                  if (rc_q == RC_LAST) begin
                     st_q    <= SEQ_IDLE;
                     done    <= 1'b1;
                     err     <= 1'b1;
                     rd_data <= '1;
                  end else begin
                     rc_q <= rc_q + 1'b1;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
   import mgmt_pkg::*;
#(
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_period,
   input  logic              start,
   input  logic              rd_nwr,
   input  logic [ADDR_W-1:0] phy_addr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              err,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam int unsigned FRAME_LEN = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;

   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end

   logic                 tick;
   logic                 run;
   logic [FRAME_LEN-1:0] frame_bits;
   logic [FRAME_LEN-1:0] frame_drive;

   mgmt_mdc_gen #(.DIV_W(DIV_W)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .half_period (half_period),
      .tick        (tick)
   );

   mgmt_frame_build #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PRE_BITS (PRE_BITS)
   ) u_build (
      .rd    (rd_nwr),
      .phy   (phy_addr),
      .regn  (reg_addr),
      .wdata (wr_data),
      .bits  (frame_bits),
      .drive (frame_drive)
   );

   mgmt_seq #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .FRAME_LEN (FRAME_LEN),
      .RECOV_LEN (RECOV_BITS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rd       (rd_nwr),
      .frame_in (frame_bits),
      .drive_in (frame_drive),
      .tick     (tick),
      .mdio_i   (mdio_i),
      .run      (run),
      .mdc      (mdc),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data  (rd_data),
      .done     (done),
      .err      (err)
   );
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk #(
   parameter int unsigned DIV_W  = 8,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DIV_W-1:0]  half_period,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              done,
   input logic              err,
   input logic [DATA_W-1:0] rd_data
);
   logic             mdc_q;
   logic [DIV_W:0]   ph_cnt;
   logic [DIV_W:0]   hp_eff;

   assign hp_eff = (half_period == '0) ? (DIV_W+1)'(1) : {1'b0, half_period};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q  <= 1'b0;
         ph_cnt <= '0;
      end else begin
         mdc_q <= mdc;
         if (mdc != mdc_q) begin
            ph_cnt <= (DIV_W+1)'(1);
         end else if (ph_cnt != '1) begin
            ph_cnt <= ph_cnt + 1'b1;
         end
      end
   end

   // R9
   line_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R9
   high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc_q && !mdc) |-> (ph_cnt == hp_eff));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mdc && !mdio_oe));

   // R8
   err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (rd_data == '1));
endmodule

bind mgmt_bus_master mgmt_bus_master_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mgmt_bus_master_tb.sv
`timescale 1ns/1ps
module mgmt_bus_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  half_period = 8'd2;
   logic        start = 1'b0;
   logic        rd_nwr = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        done, err, mdc, mdio_o, mdio_oe;
   logic        mdio_i;

   int tests = 0;
   int fails = 0;

   // PHY model
   logic        phy_bit = 1'b1;
   logic        ta_val = 1'b0;
   logic [15:0] phy_data = '0;
   int          rise_n = 0;
   int          cyc = 0;
   logic        cap_o  [0:127];
   logic        cap_oe [0:127];
   int          rise_cyc [0:127];

   assign mdio_i = mdio_oe ? mdio_o : phy_bit;

   always #4 clk = ~clk;

   mgmt_bus_master u_dut (
      .clk(clk), .rst_n(rst_n), .half_period(half_period), .start(start),
      .rd_nwr(rd_nwr), .phy_addr(phy_addr), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .done(done), .err(err),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge mdc) begin
      if (rise_n < 128) begin
         cap_o[rise_n]    = mdio_o;
         cap_oe[rise_n]   = mdio_oe;
         rise_cyc[rise_n] = cyc;
      end
      rise_n = rise_n + 1;
   end

   always @(negedge mdc) begin
      if (rise_n == 48)                     phy_bit = ta_val;
      else if (rise_n >= 49 && rise_n <= 64) phy_bit = phy_data[64 - rise_n];
      else                                   phy_bit = 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // launch one access and wait for done; checks the done pulse and idle bus
   task automatic run_access(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [7:0] hp);
      int waited = 0;
      @(negedge clk);
      half_period = hp;
      rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
      rise_n = 0; phy_bit = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      chk(done == 1'b1, "R10 done seen", done, 1);
      chk(!mdc && !mdio_oe, "R10 bus quiet at done", {mdc, mdio_oe}, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", done, 0);
   endtask

   function automatic logic [64:0] exp_frame(input bit rd, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] wd);
      return {33'h1_FFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
   endfunction

   task automatic t_reset;
      chk(!mdc, "R1 mdc low after reset", mdc, 0);
      chk(!mdio_oe, "R1 oe low after reset", mdio_oe, 0);
      chk(!done, "R1 done low after reset", done, 0);
   endtask

   task automatic t_write(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [7:0] hp);
      logic [64:0] ef = exp_frame(1'b0, pa, ra, wd);
      int bad_pre = 0, bad_hdr = 0, bad_tail = 0, bad_oe = 0;
      run_access(1'b0, pa, ra, wd, hp);
      chk(rise_n == 65, "R5 write clock count", rise_n, 65);
      for (int n = 0; n < 65; n++) begin
         if (!cap_oe[n]) bad_oe++;
         if (cap_o[n] !== ef[64-n]) begin
            if (n < 33) bad_pre++; else if (n < 47) bad_hdr++; else bad_tail++;
         end
      end
      chk(bad_pre == 0, "R2 preamble ones", bad_pre, 0);
      chk(bad_hdr == 0, "R3 R4 start opcode addresses (write)", bad_hdr, 0);
      chk(bad_tail == 0, "R5 turnaround and data", bad_tail, 0);
      chk(bad_oe == 0, "R5 all bits driven", bad_oe, 0);
   endtask

   task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] pd, input logic [7:0] hp);
      logic [64:0] ef = exp_frame(1'b1, pa, ra, 16'h0);
      int bad_hdr = 0, bad_rel = 0;
      ta_val = 1'b0; phy_data = pd;
      run_access(1'b1, pa, ra, 16'h0, hp);
      for (int n = 0; n < 47; n++)
         if (cap_o[n] !== ef[64-n] || !cap_oe[n]) bad_hdr++;
      for (int n = 47; n < 65; n++)
         if (cap_oe[n]) bad_rel++;
      chk(bad_hdr == 0, "R3 R4 read header", bad_hdr, 0);
      chk(bad_rel == 0, "R6 line released", bad_rel, 0);
      chk(rd_data == pd, "R7 read data", rd_data, pd);
      chk(err == 1'b0, "R7 no error", err, 0);
   endtask

   task automatic t_ta_error(input logic [7:0] hp);
      int bad_rel = 0;
      ta_val = 1'b1; phy_data = 16'h1234;
      run_access(1'b1, 5'h03, 5'h01, 16'h0, hp);
      chk(rise_n == 49 + 32, "R8 recovery clock count", rise_n, 81);
      for (int n = 47; n < 81; n++)
         if (cap_oe[n]) bad_rel++;
      chk(bad_rel == 0, "R8 released during recovery", bad_rel, 0);
      chk(err == 1'b1, "R8 error flag", err, 1);
      chk(rd_data == 16'hFFFF, "R8 data all ones", rd_data, 16'hFFFF);
      ta_val = 1'b0;
   endtask

   task automatic t_period(input logic [7:0] hp);
      int expd = (hp == 0) ? 2 : 2 * hp;
      run_access(1'b0, 5'h11, 5'h0A, 16'h5A5A, hp);
      chk(rise_cyc[2] - rise_cyc[1] == expd, "R9 mdc period",
          rise_cyc[2] - rise_cyc[1], expd);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write(5'h1F, 5'h00, 16'hA5C3, 8'd2);
      t_write(5'h05, 5'h1E, 16'h8001, 8'd1);
      t_read(5'h0A, 5'h15, 16'hBEEF, 8'd2);
      t_read(5'h00, 5'h1F, 16'h0001, 8'd3);
      t_ta_error(8'd2);
      t_read(5'h12, 5'h04, 16'h7FFE, 8'd1);
      t_period(8'd3);
      t_period(8'd0);
      repeat (4) @(negedge clk);
      t_reset();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule